// File: doc/BRIEF.md
# Calibrated SAR Conversion Sequencer

This block is the digital controller for a single successive-approximation converter slice. A start strobe from an upstream phase generator, taken while the slice is idle, opens a frame of a fixed length. Three housekeeping steps come first: a reference-zero sample, an offset-nulling compare and a gain-calibration compare. The slice then samples the input and resolves the code one bit per cycle, most significant bit first. A last cycle hands the finished code to the output. The comparator, the DAC and any calibration arithmetic are outside the block. The comparator decision enters as a single input bit. The trial code goes out to the DAC.

Each frame step has its own strobe. The strobes are mutually exclusive, so downstream analog switches can be driven straight from them. When several slices run in parallel, each slice is started one cycle after its neighbour. The start for a new frame can arrive in the frame's last cycle, which lets a slice run without gaps.

Top module: `sar_frame_seq`

## Requirements
- R1: A start seen at a clock edge while idle opens a frame in the next cycle. A frame runs 16 cycles (NBITS+5) in this order: cycle 1 `ph_refz`, cycle 2 `ph_az`, cycle 3 `ph_acal`, cycle 4 `ph_samp`, cycles 5 to 15 `ph_conv`, cycle 16 `res_valid`.
- R2: At most one of the six strobes (`ph_refz`, `ph_az`, `ph_acal`, `ph_samp`, `ph_conv`, `res_valid`) is high in any cycle. All six are low while idle.
- R3: `trial_code` is zero throughout the sample cycle (cycle 4).
- R4: In cycle 5 `trial_code` has only bit NBITS-1 set (value 1024 for 11 bits).
- R5: In convert cycle k (5..15), the bit under test is b = 15-k. That bit is set, the bits above it hold the earlier decisions, and the bits below it are zero. A `cmp_in` of 1 at the end of the cycle (input at or above the trial) keeps bit b; a 0 clears it.
- R6: In cycle 16 `res_valid` is high for exactly one cycle and `result` holds all eleven decisions. `result` keeps that value until the next frame's cycle 16 or a reset.
- R7: A start asserted during cycles 1 to 15 has no effect: the frame runs on unchanged and no extra frame follows.
- R8: A start seen at the end of cycle 16 opens a new frame with cycle 1 in the next cycle. Without it the slice goes idle.
- R9: `rst_n` is synchronous and active low. It returns the slice to idle with all strobes low and with `trial_code` and `result` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Frame start request from the phase generator |
| cmp_in | input | 1 | Comparator decision, 1 when the input is at or above the trial code |
| ph_refz | output | 1 | Reference-zero sampling step (cycle 1) |
| ph_az | output | 1 | Offset-nulling compare step (cycle 2) |
| ph_acal | output | 1 | Gain-calibration compare step (cycle 3) |
| ph_samp | output | 1 | Input sample step (cycle 4) |
| ph_conv | output | 1 | Bit decision step (cycles 5 to 15) |
| res_valid | output | 1 | Result transfer strobe (cycle 16) |
| trial_code | output | NBITS | Code presented to the DAC |
| result | output | NBITS | Converted code |

## Verification
The full-scale and zero inputs test the two ends of the bit decision. A design that inverts the meaning of the comparator, or drops the last bit, returns a wrong code here. Alternating-bit and mid-scale neighbour codes (1023, 1024) catch an off-by-one in the bit index, which would show as a shifted trial pattern. A start raised mid-frame would, in a design without a busy guard, restart the frame and move every strobe. A start in the final cycle tests gapless back-to-back frames, where a design that passes through idle would lose a cycle. A reset during conversion must leave no strobe high and no stale code.

// File: rtl/sar_seq_pkg.sv
// Shared types for the SAR conversion sequencer.
// Assumes: a frame is NBITS+5 cycles long (four setup steps, NBITS decisions, one transfer).
package sar_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_REFZ = 3'd1,
        PH_AZ   = 3'd2,
        PH_ACAL = 3'd3,
        PH_SAMP = 3'd4,
        PH_CONV = 3'd5,
        PH_XFER = 3'd6
    } phase_e;

endpackage

// File: rtl/sar_frame_ctr.sv
// Frame counter: tracks the position inside a conversion frame and decodes it to a phase.
// Assumes: start is sampled only while idle or in the last frame cycle; other starts are dropped.
module sar_frame_ctr
    import sar_seq_pkg::*;
#(
    parameter int NBITS = 11,
    localparam int FRAME = NBITS + 5,
    localparam int CW = $clog2(FRAME)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output phase_e        phase,
    output logic [CW-1:0] bit_idx
);

    localparam logic [CW-1:0] C_REFZ = CW'(0);
    localparam logic [CW-1:0] C_AZ   = CW'(1);
    localparam logic [CW-1:0] C_ACAL = CW'(2);
    localparam logic [CW-1:0] C_SAMP = CW'(3);
    localparam logic [CW-1:0] C_LAST = CW'(FRAME - 1);
    localparam logic [CW-1:0] C_TOP  = CW'(NBITS + 3);

    logic          busy;
    logic [CW-1:0] cyc;

    // Advance the cycle counter; accept a start only when idle or at the end of a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cyc  <= '0;
        end else if (!busy || cyc == C_LAST) begin
            busy <= start;
            cyc  <= '0;
        end else begin
            cyc  <= cyc + CW'(1);
        end
    end

    // Decode the counter position into the current step.
    always_comb begin
        if (!busy)                phase = PH_IDLE;
        else if (cyc == C_REFZ)   phase = PH_REFZ;
        else if (cyc == C_AZ)     phase = PH_AZ;
        else if (cyc == C_ACAL)   phase = PH_ACAL;
        else if (cyc == C_SAMP)   phase = PH_SAMP;
        else if (cyc == C_LAST)   phase = PH_XFER;
        else                      phase = PH_CONV;
    end

    // Bit under test: NBITS-1 in the first decision cycle, down to 0 in the last.
    assign bit_idx = C_TOP - cyc;

endmodule

// File: rtl/sar_bit_engine.sv
// Successive-approximation register: builds the trial code and captures the final result.
// Assumes: cmp_in is valid at the end of each decision cycle, 1 meaning input >= trial.
module sar_bit_engine
    import sar_seq_pkg::*;
#(
    parameter int NBITS = 11,
    localparam int CW = $clog2(NBITS + 5)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  phase_e           phase,
    input  logic [CW-1:0]    bit_idx,
    input  logic             cmp_in,
    output logic [NBITS-1:0] trial_code,
    output logic [NBITS-1:0] result
);

    localparam logic [NBITS-1:0] ONE = NBITS'(1);
    localparam logic [NBITS-1:0] MSB = ONE << (NBITS - 1);

    logic [NBITS-1:0] cur_bit;
    logic [NBITS-1:0] decided;
    logic [NBITS-1:0] next_bit;

    // Keep or drop the bit under test and pick the next bit to try.
    always_comb begin
        cur_bit  = ONE << bit_idx;
        decided  = cmp_in ? trial_code : (trial_code & ~cur_bit);
        next_bit = cur_bit >> 1;
    end

    // Clear before sampling, load the MSB trial, then resolve one bit per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trial_code <= '0;
            result     <= '0;
        end else begin
            case (phase)
                PH_ACAL: trial_code <= '0;
                PH_SAMP: trial_code <= MSB;
                PH_CONV: begin
                    trial_code <= decided | next_bit;
                    if (bit_idx == '0) result <= decided;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/sar_strobe_dec.sv
// Strobe decoder: turns the current phase into the one-hot step strobes.
// Assumes: the phase input comes from a register, so the strobes are glitch-limited.
module sar_strobe_dec
    import sar_seq_pkg::*;
(
    input  phase_e phase,
    output logic   ph_refz,
    output logic   ph_az,
    output logic   ph_acal,
    output logic   ph_samp,
    output logic   ph_conv,
    output logic   res_valid
);

    // One strobe per frame step; none while idle.
    always_comb begin
        ph_refz   = (phase == PH_REFZ);
        ph_az     = (phase == PH_AZ);
        ph_acal   = (phase == PH_ACAL);
        ph_samp   = (phase == PH_SAMP);
        ph_conv   = (phase == PH_CONV);
        res_valid = (phase == PH_XFER);
    end

endmodule

// File: rtl/sar_frame_seq.sv
// Top of the calibrated SAR conversion sequencer for one converter slice.
// Assumes: the comparator and DAC are external; cmp_in answers the trial_code shown in that cycle.
module sar_frame_seq
    import sar_seq_pkg::*;
#(
    parameter int NBITS = 11,
    localparam int CW = $clog2(NBITS + 5)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cmp_in,
    output logic             ph_refz,
    output logic             ph_az,
    output logic             ph_acal,
    output logic             ph_samp,
    output logic             ph_conv,
    output logic             res_valid,
    output logic [NBITS-1:0] trial_code,
    output logic [NBITS-1:0] result
);

    phase_e        phase;
    logic [CW-1:0] bit_idx;

    sar_frame_ctr #(.NBITS(NBITS)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .phase   (phase),
        .bit_idx (bit_idx)
    );

    sar_bit_engine #(.NBITS(NBITS)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase      (phase),
        .bit_idx    (bit_idx),
        .cmp_in     (cmp_in),
        .trial_code (trial_code),
        .result     (result)
    );

    sar_strobe_dec u_dec (
        .phase     (phase),
        .ph_refz   (ph_refz),
        .ph_az     (ph_az),
        .ph_acal   (ph_acal),
        .ph_samp   (ph_samp),
        .ph_conv   (ph_conv),
        .res_valid (res_valid)
    );

endmodule

// File: rtl/sar_frame_seq_chk.sv
// Property checker for sar_frame_seq, attached through bind.
// Assumes: rst_n is held low for at least one edge at the start of simulation.
module sar_frame_seq_chk #(
    parameter int NBITS = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ph_refz,
    input logic             ph_az,
    input logic             ph_acal,
    input logic             ph_samp,
    input logic             ph_conv,
    input logic             res_valid,
    input logic [NBITS-1:0] trial_code,
    input logic [NBITS-1:0] result
);

    localparam logic [NBITS-1:0] MSB = NBITS'(1) << (NBITS - 1);

    logic [5:0] strobes;
    assign strobes = {ph_refz, ph_az, ph_acal, ph_samp, ph_conv, res_valid};

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(strobes) <= 1);  // R2
    AST_REFZ_TO_AZ: assert property (@(posedge clk) disable iff (!rst_n)
        ph_refz |=> ph_az);  // R1
    AST_AZ_TO_ACAL: assert property (@(posedge clk) disable iff (!rst_n)
        ph_az |=> ph_acal);  // R1
    AST_ACAL_TO_SAMP: assert property (@(posedge clk) disable iff (!rst_n)
        ph_acal |=> ph_samp);  // R1
    AST_SAMPLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ph_samp |-> (trial_code == '0));  // R3
    AST_MSB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        ph_samp |=> (ph_conv && trial_code == MSB));  // R4
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);  // R6
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(result)) |-> res_valid);  // R6
    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (strobes == 6'b0 && trial_code == '0 && result == '0));  // R9

endmodule

bind sar_frame_seq sar_frame_seq_chk #(.NBITS(NBITS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ph_refz    (ph_refz),
    .ph_az      (ph_az),
    .ph_acal    (ph_acal),
    .ph_samp    (ph_samp),
    .ph_conv    (ph_conv),
    .res_valid  (res_valid),
    .trial_code (trial_code),
    .result     (result)
);

// File: tb/sar_frame_seq_test.sv
// Self-checking bench for sar_frame_seq: table-driven conversions, then directed corner cases.
module sar_frame_seq_test;

    localparam int CLK_P = 10;
    localparam int NB    = 11;
    localparam int NVEC  = 8;
    // Each entry: {input level, expected result}
    localparam logic [2*NB-1:0] VEC [NVEC] = '{
        {11'd0,    11'd0},
        {11'd2047, 11'd2047},
        {11'd1024, 11'd1024},
        {11'd1023, 11'd1023},
        {11'd1,    11'd1},
        {11'h555,  11'h555},
        {11'h2AA,  11'h2AA},
        {11'd1500, 11'd1500}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          cmp_in = 1'b0;
    logic          ph_refz, ph_az, ph_acal, ph_samp, ph_conv, res_valid;
    logic [NB-1:0] trial_code, result;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    sar_frame_seq #(.NBITS(NB)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cmp_in(cmp_in),
        .ph_refz(ph_refz), .ph_az(ph_az), .ph_acal(ph_acal), .ph_samp(ph_samp),
        .ph_conv(ph_conv), .res_valid(res_valid),
        .trial_code(trial_code), .result(result)
    );

    function automatic logic [5:0] strb();
        return {ph_refz, ph_az, ph_acal, ph_samp, ph_conv, res_valid};
    endfunction

    function automatic logic [5:0] exp_strb(input int k);
        if (k == 1)  return 6'b100000;
        if (k == 2)  return 6'b010000;
        if (k == 3)  return 6'b001000;
        if (k == 4)  return 6'b000100;
        if (k <= 15) return 6'b000010;
        return 6'b000001;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Walk one frame; the start for it was raised before the opening edge.
    task automatic run_frame(input logic [NB-1:0] vin, input logic [NB-1:0] expv,
                             input bit restart, input int mid_k);
        for (int k = 1; k <= 16; k++) begin
            @(negedge clk);
            start = 1'b0;
            chk(strb() == exp_strb(k), "R1 R2 strobe order", int'(strb()), int'(exp_strb(k)));
            if (k == 4)
                chk(trial_code == '0, "R3 trial cleared at sample", int'(trial_code), 0);
            if (k == 5)
                chk(trial_code == 11'd1024, "R4 MSB trial first", int'(trial_code), 1024);
            if (k >= 5 && k <= 15) begin
                int b = 15 - k;
                logic [NB-1:0] hi_mask = ~((NB'(1) << (b + 1)) - NB'(1));
                logic [NB-1:0] expt = (vin & hi_mask) | (NB'(1) << b);
                chk(trial_code == expt, "R5 trial pattern", int'(trial_code), int'(expt));
                cmp_in = (vin >= trial_code);
            end
            if (k == 16)
                chk(result == expv, "R6 result at transfer", int'(result), int'(expv));
            if (k == mid_k) start = 1'b1;
            if (k == 16 && restart) start = 1'b1;
        end
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(strb() == 6'b0, "R9 strobes low in reset", int'(strb()), 0);
        chk(trial_code == '0 && result == '0, "R9 codes zero in reset", int'(result), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(strb() == 6'b0, "R2 idle without start", int'(strb()), 0);

        for (int i = 0; i < NVEC; i++) begin
            start = 1'b1;
            run_frame(VEC[i][2*NB-1:NB], VEC[i][NB-1:0], 1'b0, 0);
            @(negedge clk);
            chk(strb() == 6'b0, "R8 idle after frame", int'(strb()), 0);
            chk(result == VEC[i][NB-1:0], "R6 result held", int'(result), int'(VEC[i][NB-1:0]));
        end

        // Start raised mid-frame must be ignored (R7)
        start = 1'b1;
        run_frame(11'h3A5, 11'h3A5, 1'b0, 7);
        @(negedge clk);
        chk(strb() == 6'b0, "R7 no extra frame after mid start", int'(strb()), 0);

        // Start during the last cycle chains frames with no gap (R8)
        start = 1'b1;
        run_frame(11'd100, 11'd100, 1'b1, 0);
        run_frame(11'd1900, 11'd1900, 1'b0, 0);
        @(negedge clk);
        chk(strb() == 6'b0, "R8 idle after chained frames", int'(strb()), 0);

        // Reset in the middle of a conversion (R9)
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (6) @(negedge clk);
        chk(ph_conv == 1'b1, "R1 converting before reset", int'(ph_conv), 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(strb() == 6'b0, "R9 strobes low after reset", int'(strb()), 0);
        chk(trial_code == '0 && result == '0, "R9 codes cleared", int'(trial_code), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(strb() == 6'b0, "R9 stays idle after reset", int'(strb()), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule